// File: doc/BRIEF.md
# Byte-Lane Static Memory with Control Decoding

This block is a clocked, synthesizable model of a 16-bit-wide static memory driven by active-low controls: a chip select, a write strobe, an output-enable strobe and one enable per byte lane. Every clock edge it samples the controls and decodes them into one of four modes: standby, write, read, or idle-active. Writes go into the enabled byte lanes only. Reads return data on the enabled lanes one cycle later.

The bidirectional data pins are split into three parts: a data input, a data output, and a per-lane drive-enable vector. The address has two fields. The low four bits pick a word inside a 16-word page, and the remaining bits pick the page. The block raises a page-hit flag when an access stays inside the page of the previous access, and it counts these hits. Page-mode use can therefore be observed from outside.

Address width is a parameter. A width of 18 gives the full 262,144-word array. The default is a small array so that elaboration and tests stay light.

Top module: `bytelane_sram`

## Requirements
- R1: While reset is held, and afterwards until the first access is sampled, mode is 0 (standby), drive_en is 0, dout is 0, page_hit is 0 and hit_count is 0.
- R2: When cs_n is high, mode reads 0 one cycle later. No lane is written, nothing is driven, and we_n, oe_n, the lane enables, addr and din have no effect.
- R3: When cs_n is low but lbe_n and ube_n are both high, the block is in standby (mode 0). No lane is written and nothing is driven.
- R4: When cs_n and we_n are both low, the enabled lanes at addr are written on that clock edge. oe_n is ignored, and one cycle later mode is 1 (write) and drive_en is 0.
- R5: When cs_n is low, we_n is high and oe_n is low, then one cycle later mode is 2 (read) and dout holds the stored word on the enabled lanes.
- R6: lbe_n controls bits 7:0 and drive_en[0]. ube_n controls bits 15:8 and drive_en[1]. A lane whose enable is high is neither written nor driven, and its dout bits are 0.
- R7: When cs_n is low, we_n and oe_n are both high, and at least one lane is enabled, mode is 3 (idle-active) one cycle later. drive_en is 0 and dout is 0.
- R8: The page is addr[ADDR_W-1:4], and only write and read cycles count as accesses. page_hit is 1 in the cycle after an access whose page equals that of the previous access. The first access after reset never hits, and standby and idle cycles leave the remembered page unchanged.
- R9: hit_count increments together with each page_hit and saturates at 2^HIT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output-enable strobe, active low |
| lbe_n | input | 1 | Lower byte lane enable, active low |
| ube_n | input | 1 | Upper byte lane enable, active low |
| addr | input | ADDR_W | Word address: page field above word-in-page field |
| din | input | 16 | Write data |
| dout | output | 16 | Registered read data, zero on undriven lanes |
| drive_en | output | 2 | Per-lane output drive enable (bit 1 upper, bit 0 lower) |
| mode | output | 2 | Decoded mode: 0 standby, 1 write, 2 read, 3 idle-active |
| page_hit | output | 1 | Previous sampled access stayed in the same page |
| hit_count | output | HIT_W | Saturating count of page hits |

## Verification
Every result is registered. mode, dout, drive_en, page_hit and hit_count all change on the clock edge that samples the controls, so each is due exactly one cycle after its stimulus. A write can be seen one cycle later as mode 1, and its data becomes readable on the next read, whose data is due one cycle after that read is sampled. The bench applies inputs on the falling edge and checks all outputs one nanosecond after the next rising edge, so each check falls inside the single cycle in which its result is due. To confirm that an input was ignored, the bench reads back the address it targeted.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_WRITE   = 2'd1,
    MODE_READ    = 2'd2,
    MODE_IDLE    = 2'd3
  } sram_mode_e;

  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;
endpackage

// File: rtl/sram_ctrl_decode.sv
module sram_ctrl_decode
  import sram_pkg::*;
(
  input  logic             cs_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic             lbe_n,
  input  logic             ube_n,
  output sram_mode_e       mode_d,
  output logic [LANES-1:0] wr_lane,
  output logic [LANES-1:0] rd_lane,
  output logic             access
);
  logic [LANES-1:0] lane_on;
  logic             standby;

  always_comb begin
    lane_on = {~ube_n, ~lbe_n};
    standby = cs_n || (lane_on == '0);
    if (standby)      mode_d = MODE_STANDBY;
    else if (!we_n)   mode_d = MODE_WRITE;
    else if (!oe_n)   mode_d = MODE_READ;
    else              mode_d = MODE_IDLE;
    wr_lane = (mode_d == MODE_WRITE) ? lane_on : '0;
    rd_lane = (mode_d == MODE_READ)  ? lane_on : '0;
    access  = (mode_d == MODE_WRITE) || (mode_d == MODE_READ);
  end

  always_comb begin
    a_excl_r4: assert ((wr_lane & rd_lane) == '0);
  end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [LANES-1:0]  wr_lane,
  input  logic [LANES-1:0]  rd_lane,
  output logic [DATA_W-1:0] dout,
  output logic [LANES-1:0]  drive_en
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_d, rd_q;
    logic              drv_d, drv_q;

    always_ff @(posedge clk) begin
      if (wr_lane[g]) mem[addr] <= din[g*LANE_W +: LANE_W];
    end

    always_comb begin
      drv_d = rd_lane[g];
      rd_d  = rd_lane[g] ? mem[addr] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_q  <= '0;
        drv_q <= 1'b0;
      end else begin
        rd_q  <= rd_d;
        drv_q <= drv_d;
      end
    end

    assign dout[g*LANE_W +: LANE_W] = rd_q;
    assign drive_en[g]              = drv_q;

    p_lane_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_en[g] |-> dout[g*LANE_W +: LANE_W] == '0);
  end
endmodule

// File: rtl/sram_page_tracker.sv
module sram_page_tracker #(
  parameter int PAGE_W = 6,
  parameter int HIT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access,
  input  logic [PAGE_W-1:0] page,
  output logic              page_hit,
  output logic [HIT_W-1:0]  hit_count
);
  localparam logic [HIT_W-1:0] CNT_MAX = '1;

  logic [PAGE_W-1:0] prev_q, prev_d;
  logic              valid_q, valid_d;
  logic              hit_d, hit_q;
  logic [HIT_W-1:0]  cnt_d, cnt_q;

  always_comb begin
    hit_d   = access && valid_q && (page == prev_q);
    prev_d  = access ? page : prev_q;
    valid_d = valid_q || access;
    cnt_d   = (hit_d && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      prev_q  <= prev_d;
      valid_q <= valid_d;
      hit_q   <= hit_d;
      cnt_q   <= cnt_d;
    end
  end

  assign page_hit  = hit_q;
  assign hit_count = cnt_q;

  p_count_monotonic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> hit_count >= $past(hit_count));
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count != $past(hit_count)) |-> page_hit);
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int HIT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              lbe_n,
  input  logic              ube_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  output logic [1:0]        drive_en,
  output logic [1:0]        mode,
  output logic              page_hit,
  output logic [HIT_W-1:0]  hit_count
);
  localparam int OFFS_W = 4;
  localparam int PAGE_W = ADDR_W - OFFS_W;

  logic       rst_s1, rst_sync_n;
  sram_mode_e mode_d, mode_q;
  logic [LANES-1:0] wr_lane, rd_lane;
  logic       access;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  sram_ctrl_decode u_dec (
    .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .lbe_n(lbe_n), .ube_n(ube_n),
    .mode_d(mode_d), .wr_lane(wr_lane), .rd_lane(rd_lane), .access(access)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mode_q <= MODE_STANDBY;
    else             mode_q <= mode_d;
  end
  assign mode = mode_q;

  sram_lane_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .rst_n(rst_sync_n), .addr(addr), .din(din),
    .wr_lane(wr_lane), .rd_lane(rd_lane), .dout(dout), .drive_en(drive_en)
  );

  sram_page_tracker #(.PAGE_W(PAGE_W), .HIT_W(HIT_W)) u_pg (
    .clk(clk), .rst_n(rst_sync_n), .access(access),
    .page(addr[ADDR_W-1:OFFS_W]), .page_hit(page_hit), .hit_count(hit_count)
  );

  p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_q == MODE_STANDBY |-> drive_en == '0);
  p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_q == MODE_WRITE |-> drive_en == '0);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_q == MODE_IDLE |-> (drive_en == '0 && dout == '0));
  p_drive_is_read_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    drive_en != '0 |-> mode_q == MODE_READ);
  p_hit_on_access_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    page_hit |-> (mode_q == MODE_WRITE || mode_q == MODE_READ));
endmodule

// File: tb/bytelane_sram_test.sv
`timescale 1ns/1ps
module bytelane_sram_test;
  localparam int AW = 10;
  localparam int HW = 4;

  logic          clk = 1'b0;
  logic          rst_n, cs_n, we_n, oe_n, lbe_n, ube_n;
  logic [AW-1:0] addr;
  logic [15:0]   din, dout;
  logic [1:0]    drive_en, mode;
  logic          page_hit;
  logic [HW-1:0] hit_count;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bytelane_sram #(.ADDR_W(AW), .HIT_W(HW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .lbe_n(lbe_n), .ube_n(ube_n), .addr(addr), .din(din), .dout(dout),
    .drive_en(drive_en), .mode(mode), .page_hit(page_hit), .hit_count(hit_count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply inputs on falling edge, sample 1 ns after next rising edge
  task automatic cyc(input logic c, input logic w, input logic o, input logic l,
                     input logic u, input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    cs_n = c; we_n = w; oe_n = o; lbe_n = l; ube_n = u; addr = a; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    lbe_n = 1'b1; ube_n = 1'b1; addr = '0; din = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 mode", mode, 2'd0);
    chk("R1 drive_en", drive_en, 2'b00);
    chk("R1 dout", dout, 16'h0);
    chk("R1 page_hit", page_hit, 1'b0);
    chk("R1 hit_count", hit_count, 0);
  endtask

  task automatic t_write_read();
    cyc(0, 0, 0, 0, 0, 10'd5, 16'h1234);
    chk("R4 mode write", mode, 2'd1);
    chk("R4 no drive with oe low", drive_en, 2'b00);
    cyc(0, 1, 0, 0, 0, 10'd5, 16'h0);
    chk("R5 mode read", mode, 2'd2);
    chk("R5 dout", dout, 16'h1234);
    chk("R5 drive_en", drive_en, 2'b11);
  endtask

  task automatic t_lanes();
    cyc(0, 0, 1, 0, 0, 10'd6, 16'h1111);
    cyc(0, 0, 1, 0, 1, 10'd6, 16'h22BB);
    cyc(0, 1, 0, 0, 0, 10'd6, 16'h0);
    chk("R6 lower-only write", dout, 16'h11BB);
    cyc(0, 1, 0, 1, 0, 10'd6, 16'h0);
    chk("R6 upper read dout", dout, 16'h1100);
    chk("R6 upper read drive", drive_en, 2'b10);
    cyc(0, 1, 0, 0, 1, 10'd6, 16'h0);
    chk("R6 lower read dout", dout, 16'h00BB);
    chk("R6 lower read drive", drive_en, 2'b01);
  endtask

  task automatic t_standby();
    cyc(1, 0, 0, 0, 0, 10'd5, 16'hFFFF);
    chk("R2 mode", mode, 2'd0);
    chk("R2 drive_en", drive_en, 2'b00);
    chk("R2 dout", dout, 16'h0);
    cyc(0, 1, 0, 0, 0, 10'd5, 16'h0);
    chk("R2 no write", dout, 16'h1234);
    cyc(0, 0, 0, 1, 1, 10'd5, 16'hEEEE);
    chk("R3 mode", mode, 2'd0);
    chk("R3 drive_en", drive_en, 2'b00);
    cyc(0, 1, 0, 0, 0, 10'd5, 16'h0);
    chk("R3 no write", dout, 16'h1234);
  endtask

  task automatic t_idle();
    cyc(0, 1, 1, 0, 0, 10'd5, 16'h0);
    chk("R7 mode", mode, 2'd3);
    chk("R7 drive_en", drive_en, 2'b00);
    chk("R7 dout", dout, 16'h0);
  endtask

  task automatic t_page();
    do_reset();
    cyc(0, 1, 0, 0, 0, 10'h020, 16'h0);
    chk("R8 first access no hit", page_hit, 1'b0);
    cyc(0, 1, 0, 0, 0, 10'h025, 16'h0);
    chk("R8 same page hit", page_hit, 1'b1);
    cyc(0, 1, 1, 0, 0, 10'h090, 16'h0);
    chk("R8 idle no hit", page_hit, 1'b0);
    cyc(0, 0, 1, 0, 0, 10'h02F, 16'h0);
    chk("R8 idle keeps page", page_hit, 1'b1);
    cyc(0, 1, 0, 0, 0, 10'h030, 16'h0);
    chk("R8 new page miss", page_hit, 1'b0);
    cyc(1, 1, 0, 0, 0, 10'h030, 16'h0);
    chk("R8 standby no hit", page_hit, 1'b0);
    cyc(0, 1, 0, 0, 0, 10'h031, 16'h0);
    chk("R8 hit after standby", page_hit, 1'b1);
    chk("R9 count 3", hit_count, 3);
  endtask

  task automatic t_sat();
    do_reset();
    for (int i = 0; i < 20; i++) begin
      cyc(0, 1, 0, 0, 0, 10'h040 + 10'(i % 16), 16'h0);
      if (i == 15) chk("R9 count reaches max", hit_count, 15);
    end
    chk("R9 saturated", hit_count, 15);
    chk("R9 hit still flagged", page_hit, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    lbe_n = 1'b1; ube_n = 1'b1; addr = '0; din = '0;
    t_reset();
    t_write_read();
    t_lanes();
    t_standby();
    t_idle();
    t_page();
    t_sat();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule